// File: doc/BRIEF.md
# Pattern-Masked Write Data Deserializer

This block rebuilds a write data packet that arrives one bit at a time on several parallel data lanes. It produces the packet bytes together with a write enable for each byte. Each lane carries two whole bytes per packet, so a packet takes sixteen accepted bit times. A byte never spans two lanes, so changing the lane count changes only how many bytes a packet holds. On lane `i` of `L` lanes, byte `i` arrives first and byte `L+i` follows. Within each byte the least significant bit comes first.

Masking is carried in the data itself. A masked write supplies an 8-bit reserved pattern. Any byte of that packet whose value equals the pattern gets its enable cleared. A plain write enables every byte. The pattern and the mode flag are sampled with the packet start pulse.

The serial side is a valid/ready stream of one bit per lane per beat. The packet side is a valid/ready stream of whole packets. Back-pressure works as follows:
- A finished packet stays on the outputs until the consumer takes it.
- If the next packet reaches its last bit while the previous one is still waiting, the block refuses that bit by dropping `in_ready` until the output slot frees.
- `pkt_start` and the command fields are plain control pins and are never back-pressured.

Top module: `mwd_deser`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `L` lanes, the first byte received on lane `i` appears as byte `i` and the second as byte `L+i`. Byte `j` occupies `out_data[8j+7:8j]`, and its enable is `out_be[j]`.
- R3: Within each byte the first accepted bit becomes bit 0 and later bits fill bits 1 to 7 in ascending order.
- R4: In a masked write (`masked_wr`=1 at start), `out_be[j]` is 0 exactly when byte `j` equals the captured pattern, and 1 otherwise.
- R5: In a plain write (`masked_wr`=0 at start), every bit of `out_be` is 1 whatever the data.
- R6: `mask_pat` and `masked_wr` are sampled only in the cycle `pkt_start` is high. Changing them later in the packet has no effect.
- R7: `out_valid` rises in the cycle after the sixteenth accepted bit of a packet. `out_data` and `out_be` are updated in that same cycle.
- R8: A `pkt_start` pulse during an unfinished packet discards it and restarts at bit time 0. A bit accepted with the pulse is bit 0. The discarded packet never raises `out_valid`.
- R9: Bits accepted while no packet is open are dropped and produce no output.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_be` are held. `in_ready` is 0 only when a packet's last bit is pending and the output slot is full. A packet finishing in the cycle the slot is read out replaces it with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_start | input | 1 | One-cycle pulse opening a packet; samples the command fields |
| masked_wr | input | 1 | 1 = masked write, 0 = plain write |
| mask_pat | input | 8 | Reserved byte value that disables a byte in a masked write |
| in_valid | input | 1 | Serial beat valid, one bit per lane |
| in_ready | output | 1 | Serial beat accepted when high together with `in_valid` |
| lane_bits | input | LANES | Current bit of each lane, lane `i` on bit `i` |
| out_valid | output | 1 | Assembled packet available |
| out_ready | input | 1 | Consumer takes the packet |
| out_data | output | 16*LANES | Packet bytes, byte `j` at bits `8j+7:8j` |
| out_be | output | 2*LANES | Per-byte write enable |

## Verification
The bench aims at the lane-to-byte mapping and the bit order with random data:
- A swapped byte pair or a reversed shift would put data in the wrong slot or mirror it.
- Masked packets are salted with bytes equal to the pattern, and the same bytes are sent in plain mode. An inverted or mode-blind compare shows up as wrong enables.

It also changes the pattern and mode inside a packet, which catches a design that samples them late. It aborts a packet halfway and sends stray bits with no packet open. A counter that failed to restart would then emit a packet early or corrupted. Holding `out_ready` low checks that the waiting packet stays frozen and that the last bit of the next packet is stalled, not lost.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int BYTE_W        = 8;
  localparam int BYTES_PER_LN  = 2;
  localparam int BITS_PER_LN   = BYTE_W * BYTES_PER_LN;

  typedef logic [BYTE_W-1:0] byte_t;

  // A byte is written unless masking is on and it matches the reserved value.
  function automatic logic byte_write_ok(input byte_t value, input byte_t pattern,
                                         input logic masked);
    return !masked || (value != pattern);
  endfunction
endpackage

// File: rtl/mwd_lane_shift.sv
module mwd_lane_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] q_next
);
  logic [WIDTH-1:0] q;

  // Shift right with the newest bit at the top: after WIDTH shifts the
  // first bit sits at position 0, matching a least-significant-first order.
  always_comb q_next = shift_en ? {bit_in, q[WIDTH-1:1]} : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/mwd_pattern_cmp.sv
module mwd_pattern_cmp
  import mwd_pkg::*;
#(
  parameter int NBYTES = 32
) (
  input  logic [NBYTES*BYTE_W-1:0] bytes_in,
  input  byte_t                    pattern,
  input  logic                     masked,
  output logic [NBYTES-1:0]        enables
);
  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    assign enables[j] = byte_write_ok(bytes_in[j*BYTE_W +: BYTE_W], pattern, masked);
  end
endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl #(
  parameter int BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic out_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic shift_en,
  output logic done
);
  localparam int CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             at_last;
  logic             accept;

  assign at_last  = active && !start && (cnt == LAST);
  assign in_ready = !(at_last && out_valid && !out_ready);
  assign accept   = in_valid && in_ready;
  assign shift_en = accept && (active || start);
  assign done     = accept && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= accept ? CNT_W'(1) : '0;
    end else if (shift_en) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R9: with no packet open the bit counter rests at zero
  assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cnt == '0);
  // R8: a start pulse always leaves a packet open
  assert_start_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active || (cnt == '0));
endmodule

// File: rtl/mwd_deser.sv
module mwd_deser
  import mwd_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_start,
  input  logic                         masked_wr,
  input  logic [BYTE_W-1:0]            mask_pat,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES-1:0]             lane_bits,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [LANES*BITS_PER_LN-1:0] out_data,
  output logic [2*LANES-1:0]           out_be
);
  localparam int NBYTES = BYTES_PER_LN * LANES;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              shift_en;
  logic              done;
  logic              mode_q;
  byte_t             pat_q;
  logic [DATA_W-1:0] assembled;
  logic [NBYTES-1:0] enables;

  mwd_ctrl #(.BITS(BITS_PER_LN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (pkt_start),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .shift_en (shift_en),
    .done     (done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BITS_PER_LN-1:0] lane_q;
    mwd_lane_shift #(.WIDTH(BITS_PER_LN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .bit_in  (lane_bits[i]),
      .q_next  (lane_q)
    );
    // earlier byte of the lane -> byte i, later byte -> byte LANES+i
    assign assembled[i*BYTE_W +: BYTE_W]           = lane_q[BYTE_W-1:0];
    assign assembled[(LANES+i)*BYTE_W +: BYTE_W]   = lane_q[BITS_PER_LN-1:BYTE_W];
  end

  mwd_pattern_cmp #(.NBYTES(NBYTES)) u_cmp (
    .bytes_in(assembled),
    .pattern (pat_q),
    .masked  (mode_q),
    .enables (enables)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pat_q  <= '0;
    end else if (pkt_start) begin
      mode_q <= masked_wr;
      pat_q  <= mask_pat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_data  <= assembled;
      out_be    <= enables;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a packet that is not taken stays frozen
  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be));
  // R10: the serial side is only stalled by a full output slot
  assert_stall_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);
  // R7: the sixteenth accepted bit yields a packet on the next cycle
  assert_done_to_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> out_valid);
  // R5: a plain write leaves every byte enabled
  assert_plain_all_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_q |=> &out_be);
endmodule

// File: tb/test_mwd_deser.sv
module test_mwd_deser;
  localparam int L  = 16;
  localparam int NB = 2 * L;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_start = 1'b0;
  logic          masked_wr = 1'b0;
  logic [7:0]    mask_pat = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [L-1:0]  lane_bits = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [NB-1:0] out_be;

  int total = 0;
  int failed = 0;
  bit finished = 0;
  logic [7:0] pk [NB];

  always #5 clk = ~clk;

  mwd_deser #(.LANES(L)) i_mwd_deser (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .masked_wr(masked_wr),
    .mask_pat(mask_pat), .in_valid(in_valid), .in_ready(in_ready),
    .lane_bits(lane_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_be(out_be)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_data();
    logic [DW-1:0] v;
    for (int j = 0; j < NB; j++) v[j*8 +: 8] = pk[j];
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_be(input logic m, input logic [7:0] p);
    logic [DW-1:0] v = '0;
    for (int j = 0; j < NB; j++) v[j] = !m || (pk[j] != p);
    return v;
  endfunction

  task automatic fill(input logic [7:0] p, input int hits);
    for (int j = 0; j < NB; j++) pk[j] = 8'($urandom);
    for (int h = 0; h < hits; h++) pk[$urandom % NB] = p;
  endtask

  // Drives bit times 0..nbits-1 of pk; start on bit 0; optional field change after bit 0.
  task automatic send(input logic m, input logic [7:0] p, input int nbits, input bit twist);
    for (int t = 0; t < nbits; t++) begin
      @(negedge clk);
      pkt_start = (t == 0);
      masked_wr = (t == 0 || !twist) ? m : ~m;
      mask_pat  = (t == 0 || !twist) ? p : ~p;
      in_valid  = 1'b1;
      for (int i = 0; i < L; i++)
        lane_bits[i] = (t < 8) ? pk[i][t] : pk[L+i][t-8];
      @(posedge clk);
      #1;
    end
    @(negedge clk);
    pkt_start = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", DW'(out_valid), DW'(0));
    check("R1 in_ready", DW'(in_ready), DW'(1));
  endtask

  task automatic t_plain();
    logic [7:0] p = 8'h5A;
    for (int r = 0; r < 3; r++) begin
      fill(p, 4);
      send(1'b0, p, 16, 1'b0);
      #1;
      check("R7 out_valid", DW'(out_valid), DW'(1));
      check("R2 R3 data plain", out_data, exp_data());
      check("R5 all enabled", DW'(out_be), exp_be(1'b0, p));
      @(posedge clk); #1;
      check("R7 single pulse", DW'(out_valid), DW'(0));
    end
  endtask

  task automatic t_masked();
    for (int r = 0; r < 4; r++) begin
      logic [7:0] p = 8'($urandom);
      fill(p, 3 + r);
      send(1'b1, p, 16, 1'b0);
      #1;
      check("R2 R3 data masked", out_data, exp_data());
      check("R4 enables", DW'(out_be), exp_be(1'b1, p));
    end
  endtask

  task automatic t_twist();
    logic [7:0] p = 8'hC3;
    fill(p, 6);
    send(1'b1, p, 16, 1'b1);
    #1;
    check("R6 masked kept", DW'(out_be), exp_be(1'b1, p));
    fill(p, 6);
    send(1'b0, p, 16, 1'b1);
    #1;
    check("R6 plain kept", DW'(out_be), exp_be(1'b0, p));
  endtask

  task automatic t_abort();
    logic [7:0] p = 8'h00;
    fill(p, 2);
    send(1'b1, p, 7, 1'b0);
    check("R8 no output for partial", DW'(out_valid), DW'(0));
    fill(p, 5);
    send(1'b1, p, 15, 1'b0);
    check("R8 no early output", DW'(out_valid), DW'(0));
    send(1'b1, p, 16, 1'b0);
    #1;
    check("R8 restarted data", out_data, exp_data());
    check("R8 restarted enables", DW'(out_be), exp_be(1'b1, p));
  endtask

  task automatic t_idle();
    bit bad = 0;
    bit stall = 0;
    repeat (20) begin
      @(negedge clk);
      in_valid  = 1'b1;
      lane_bits = L'($urandom);
      if (!in_ready) stall = 1;
      @(posedge clk); #1;
      if (out_valid) bad = 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 stray bits ignored", DW'(bad), DW'(0));
    check("R9 stray bits accepted", DW'(stall), DW'(0));
  endtask

  task automatic t_backpressure();
    logic [7:0] p = 8'hA5;
    logic [DW-1:0] a_data;
    logic [DW-1:0] a_be;
    out_ready = 1'b0;
    fill(p, 4);
    send(1'b1, p, 16, 1'b0);
    a_data = exp_data();
    a_be   = exp_be(1'b1, p);
    fill(p, 4);
    send(1'b1, p, 15, 1'b0);
    @(negedge clk);
    in_valid = 1'b1;
    for (int i = 0; i < L; i++) lane_bits[i] = pk[L+i][7];
    #1;
    check("R10 last bit stalled", DW'(in_ready), DW'(0));
    repeat (3) @(posedge clk);
    #1;
    check("R10 held valid", DW'(out_valid), DW'(1));
    check("R10 held data", out_data, a_data);
    check("R10 held enables", DW'(out_be), a_be);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R10 stall released", DW'(in_ready), DW'(1));
    @(posedge clk); #1;
    check("R10 back-to-back valid", DW'(out_valid), DW'(1));
    check("R10 next data", out_data, exp_data());
    check("R10 next enables", DW'(out_be), exp_be(1'b1, p));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_plain();
    t_masked();
    t_twist();
    t_abort();
    t_idle();
    t_backpressure();
    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule